// File: doc/BRIEF.md
# Boot Overlay and Peripheral Strobe Decoder

This block holds the local address logic of a small coprocessor card built around an 8-bit processor. Right after reset a boot overlay is active. While it is active, address bit 14 seen by memory is forced high. Any access aimed at the bottom quarter of the map (0x0000–0x3FFF) therefore lands one quarter higher, in the ROM window (0x4000–0x7FFF). The processor's first opcode fetch from 0x0000 is served from 0x4000, the first ROM byte. A small fetch counter, cleared by reset, removes the overlay once a fixed number of opcode fetches has been seen. The overlay stays off until the next reset.

The block also turns accesses inside one memory-mapped window (0x8000–0xBFFF) into single-cycle peripheral strobes. An access begins on the rising edge of the internal access strobe, with exactly one of read or write asserted. The three lowest bits of the address select the strobe. The decoded strobes are:
- an enable for the interrupt controller, which covers two neighbouring addresses so both of its programming registers can be reached;
- a set-bus-interrupt strobe;
- an interrupt-acknowledge strobe;
- two strobes that load the middle (bits 8–15) and upper (bits 16–23) bytes of an extended bus address;
- a strobe that loads the interrupt response byte.

Decoding uses the remapped address.

Top module: `boot_strobe_decode`

## Requirements
- R1: In the first cycle after a synchronous reset, `overlay_on` is 1 and every strobe output is 0.
- R2: While `overlay_on` is 1, `mem_addr` equals `addr` with bit 14 forced to 1, so 0x0000 appears as 0x4000 and 0x1234 as 0x5234.
- R3: An opcode-fetch start is a rising edge of `acc_stb` sampled with `fetch` and `rd` both 1. The overlay turns off after the clock edge that samples the 8th such start. Starts without `fetch`, or without `rd`, are not counted.
- R4: Once `overlay_on` is 0, it stays 0 until reset, and `mem_addr` equals `addr` exactly.
- R5: A qualified access starts when a rising edge of `acc_stb` is sampled with exactly one of `rd`/`wr` at 1 and remapped bits [15:14] = 2'b10. The low three address bits pick the strobe:
  - 0 or 1: `ictl_en`
  - 2: `set_bus_int`
  - 3: `iack_stb`
  - 4: `xaddr_mid_stb`
  - 5: `xaddr_hi_stb`
  - 6: `irsp_ld`
  - 7: no strobe
- R6: The strobe is high in the cycle after the edge that samples the start. It lasts exactly one cycle, even if `acc_stb` stays high.
- R7: At most one strobe output is high in any cycle.
- R8: No strobe fires in any of these cases: the address is outside the window; `acc_stb` shows no rising edge; `rd` and `wr` are both 1; `rd` and `wr` are both 0.
- R9: While `overlay_on` is 1, a window address such as 0x8002 is remapped to 0xC002, so no strobe fires.
- R10: A reset applied after the overlay has cleared turns the overlay back on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | Processor address |
| acc_stb | input | 1 | Internal access strobe; rising edge starts an access |
| rd | input | 1 | Read cycle |
| wr | input | 1 | Write cycle |
| fetch | input | 1 | Current read is an opcode fetch |
| mem_addr | output | 16 | Remapped address (bit 14 ORed with overlay) |
| overlay_on | output | 1 | Boot overlay active |
| ictl_en | output | 1 | Interrupt controller enable strobe |
| set_bus_int | output | 1 | Set bus interrupt strobe |
| iack_stb | output | 1 | Interrupt acknowledge strobe |
| xaddr_mid_stb | output | 1 | Extended address bits 8–15 load strobe |
| xaddr_hi_stb | output | 1 | Extended address bits 16–23 load strobe |
| irsp_ld | output | 1 | Interrupt response byte load strobe |

## Verification
The assertions assume that `acc_stb` drops between two accesses, so every access produces exactly one rising edge. They also assume that `addr`, `rd`, `wr` and `fetch` are steady while `acc_stb` is high. The stimulus drives all inputs on the falling clock edge and holds them for the whole access. Each access ends with `acc_stb` low for at least one cycle, and the hold scenario only stretches the high phase. The illegal read/write combinations appear only as deliberate cases in the bench.

// File: rtl/bsd_pkg.sv
package bsd_pkg;

    localparam int ADDR_W  = 16;
    localparam int SEL_W   = 3;
    localparam int NUM_STB = 6;

    typedef struct packed {
        logic irsp_ld;
        logic xaddr_hi;
        logic xaddr_mid;
        logic iack;
        logic set_int;
        logic ictl_en;
    } stb_vec_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_ICTL_A = 3'd0,
        SEL_ICTL_B = 3'd1,
        SEL_SETINT = 3'd2,
        SEL_IACK   = 3'd3,
        SEL_XMID   = 3'd4,
        SEL_XHI    = 3'd5,
        SEL_IRSP   = 3'd6,
        SEL_NONE   = 3'd7
    } sel_code_e;

    typedef struct packed {
        logic start;
        logic rd;
        logic wr;
        logic fetch;
    } acc_t;

    function automatic stb_vec_t sel_to_stb(input logic [SEL_W-1:0] code);
        stb_vec_t v;
        v = '0;
        case (sel_code_e'(code))
            SEL_ICTL_A, SEL_ICTL_B: v.ictl_en   = 1'b1;
            SEL_SETINT:             v.set_int   = 1'b1;
            SEL_IACK:               v.iack      = 1'b1;
            SEL_XMID:               v.xaddr_mid = 1'b1;
            SEL_XHI:                v.xaddr_hi  = 1'b1;
            SEL_IRSP:               v.irsp_ld   = 1'b1;
            default:                v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/bsd_access_edge.sv
module bsd_access_edge
    import bsd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic stb_in,
    input  logic rd,
    input  logic wr,
    input  logic fetch,
    output acc_t acc_o
);
    logic stb_prev;

    always_ff @(posedge clk) begin
        if (rst) stb_prev <= 1'b0;
        else     stb_prev <= stb_in;
    end

    always_comb begin
        acc_o.start = stb_in & ~stb_prev;
        acc_o.rd    = rd;
        acc_o.wr    = wr;
        acc_o.fetch = fetch;
    end
endmodule

// File: rtl/bsd_boot_ctr.sv
module bsd_boot_ctr #(
    parameter int BOOT_FETCHES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic fetch_seen,
    output logic overlay
);
    localparam int CNT_W = $clog2(BOOT_FETCHES + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(BOOT_FETCHES);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (fetch_seen && cnt != LIMIT)
            cnt <= cnt + 1'b1;
    end

    assign overlay = (cnt != LIMIT);
endmodule

// File: rtl/bsd_window_dec.sv
module bsd_window_dec
    import bsd_pkg::*;
#(
    parameter int             A_W       = ADDR_W,
    parameter int             OVL_BIT   = 14,
    parameter int             TAG_W     = 2,
    parameter logic [TAG_W-1:0] WIN_TAG = 2'b10
) (
    input  logic [A_W-1:0] addr,
    input  logic           overlay,
    input  logic           start,
    input  logic           rd,
    input  logic           wr,
    output logic [A_W-1:0] eff_addr,
    output stb_vec_t       hit
);
    logic win_hit;
    logic valid;

    generate
        for (genvar b = 0; b < A_W; b++) begin : g_map
            if (b == OVL_BIT) begin : g_force
                assign eff_addr[b] = addr[b] | overlay;
            end else begin : g_pass
                assign eff_addr[b] = addr[b];
            end
        end
    endgenerate

    assign win_hit = (eff_addr[A_W-1 -: TAG_W] == WIN_TAG);
    assign valid   = start & (rd ^ wr) & win_hit;
    assign hit     = valid ? sel_to_stb(eff_addr[SEL_W-1:0]) : '0;
endmodule

// File: rtl/boot_strobe_decode.sv
module boot_strobe_decode
    import bsd_pkg::*;
#(
    parameter int BOOT_FETCHES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              acc_stb,
    input  logic              rd,
    input  logic              wr,
    input  logic              fetch,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              overlay_on,
    output logic              ictl_en,
    output logic              set_bus_int,
    output logic              iack_stb,
    output logic              xaddr_mid_stb,
    output logic              xaddr_hi_stb,
    output logic              irsp_ld
);
    acc_t     acc;
    logic     overlay;
    stb_vec_t hit;
    stb_vec_t stb_q;

    bsd_access_edge i_edge (
        .clk   (clk),
        .rst   (rst),
        .stb_in(acc_stb),
        .rd    (rd),
        .wr    (wr),
        .fetch (fetch),
        .acc_o (acc)
    );

    bsd_boot_ctr #(.BOOT_FETCHES(BOOT_FETCHES)) i_boot (
        .clk       (clk),
        .rst       (rst),
        .fetch_seen(acc.start & acc.fetch & acc.rd),
        .overlay   (overlay)
    );

    bsd_window_dec i_dec (
        .addr    (addr),
        .overlay (overlay),
        .start   (acc.start),
        .rd      (acc.rd),
        .wr      (acc.wr),
        .eff_addr(mem_addr),
        .hit     (hit)
    );

    always_ff @(posedge clk) begin
        if (rst) stb_q <= '0;
        else     stb_q <= hit;
    end

    assign overlay_on    = overlay;
    assign ictl_en       = stb_q.ictl_en;
    assign set_bus_int   = stb_q.set_int;
    assign iack_stb      = stb_q.iack;
    assign xaddr_mid_stb = stb_q.xaddr_mid;
    assign xaddr_hi_stb  = stb_q.xaddr_hi;
    assign irsp_ld       = stb_q.irsp_ld;
endmodule

// File: rtl/bsd_checker.sv
module bsd_checker (
    input logic        clk,
    input logic        rst,
    input logic [15:0] addr,
    input logic        acc_stb,
    input logic [15:0] mem_addr,
    input logic        overlay_on,
    input logic        ictl_en,
    input logic        set_bus_int,
    input logic        iack_stb,
    input logic        xaddr_mid_stb,
    input logic        xaddr_hi_stb,
    input logic        irsp_ld
);
    logic [5:0] s;
    assign s = {irsp_ld, xaddr_hi_stb, xaddr_mid_stb, iack_stb, set_bus_int, ictl_en};

    a_r2_overlay_forces_bit: assert property (@(posedge clk) disable iff (rst)
        overlay_on |-> (mem_addr[14] && mem_addr[13:0] == addr[13:0] && mem_addr[15] == addr[15]));

    a_r4_overlay_sticky: assert property (@(posedge clk) disable iff (rst)
        !overlay_on |=> !overlay_on);

    a_r4_passthrough: assert property (@(posedge clk) disable iff (rst)
        !overlay_on |-> mem_addr == addr);

    a_r7_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0(s));

    a_r6_single_cycle: assert property (@(posedge clk) disable iff (rst)
        (s != 6'd0) |=> (s == 6'd0));

    a_r6_follows_strobe: assert property (@(posedge clk) disable iff (rst)
        (s != 6'd0) |-> $past(acc_stb));

    a_r9_quiet_in_boot: assert property (@(posedge clk) disable iff (rst)
        (s != 6'd0) |-> !$past(overlay_on));
endmodule

bind boot_strobe_decode bsd_checker i_bsd_checker (
    .clk          (clk),
    .rst          (rst),
    .addr         (addr),
    .acc_stb      (acc_stb),
    .mem_addr     (mem_addr),
    .overlay_on   (overlay_on),
    .ictl_en      (ictl_en),
    .set_bus_int  (set_bus_int),
    .iack_stb     (iack_stb),
    .xaddr_mid_stb(xaddr_mid_stb),
    .xaddr_hi_stb (xaddr_hi_stb),
    .irsp_ld      (irsp_ld)
);

// File: tb/test_boot_strobe_decode.sv
module test_boot_strobe_decode;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] addr = '0;
    logic        acc_stb = 1'b0, rd = 1'b0, wr = 1'b0, fetch = 1'b0;
    logic [15:0] mem_addr;
    logic        overlay_on;
    logic        ictl_en, set_bus_int, iack_stb, xaddr_mid_stb, xaddr_hi_stb, irsp_ld;

    int n_chk = 0;
    int n_bad = 0;

    boot_strobe_decode i_boot_strobe_decode (
        .clk(clk), .rst(rst), .addr(addr), .acc_stb(acc_stb), .rd(rd), .wr(wr),
        .fetch(fetch), .mem_addr(mem_addr), .overlay_on(overlay_on),
        .ictl_en(ictl_en), .set_bus_int(set_bus_int), .iack_stb(iack_stb),
        .xaddr_mid_stb(xaddr_mid_stb), .xaddr_hi_stb(xaddr_hi_stb), .irsp_ld(irsp_ld)
    );

    always #4 clk = ~clk;

    function automatic logic [5:0] strobes();
        return {irsp_ld, xaddr_hi_stb, xaddr_mid_stb, iack_stb, set_bus_int, ictl_en};
    endfunction

    function automatic logic [5:0] expect_code(input logic [2:0] c);
        case (c)
            3'd0, 3'd1: return 6'b000001;
            3'd2:       return 6'b000010;
            3'd3:       return 6'b000100;
            3'd4:       return 6'b001000;
            3'd5:       return 6'b010000;
            3'd6:       return 6'b100000;
            default:    return 6'b000000;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; acc_stb = 1'b0; rd = 1'b0; wr = 1'b0; fetch = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic access(input string req, input logic [15:0] a, input logic r, input logic w,
                          input logic f, input int hold, input logic [5:0] exp);
        @(negedge clk);
        addr = a; rd = r; wr = w; fetch = f; acc_stb = 1'b1;
        @(posedge clk); #1;
        chk(req, strobes(), exp);
        chk("R7", $countones(strobes()) <= 1, 1);
        for (int i = 0; i < hold; i++) begin
            @(posedge clk); #1;
            chk("R6", strobes(), 6'd0);
        end
        @(negedge clk);
        acc_stb = 1'b0; rd = 1'b0; wr = 1'b0; fetch = 1'b0;
        @(posedge clk); #1;
        chk(req, strobes(), 6'd0);
    endtask

    task automatic probe(input string req, input logic [15:0] a, input logic [15:0] exp);
        @(negedge clk);
        addr = a;
        #1;
        chk(req, mem_addr, exp);
    endtask

    task automatic t_reset();
        do_reset();
        @(posedge clk); #1;
        chk("R1", overlay_on, 1'b1);
        chk("R1", strobes(), 6'd0);
        probe("R2", 16'h0000, 16'h4000);
    endtask

    task automatic t_overlay_map();
        probe("R2", 16'h1234, 16'h5234);
        probe("R2", 16'hB7F0, 16'hF7F0);
        access("R9", 16'h8002, 1'b0, 1'b1, 1'b0, 0, 6'd0);
        access("R9", 16'h8000, 1'b1, 1'b0, 1'b0, 0, 6'd0);
    endtask

    task automatic t_nonfetch();
        for (int i = 0; i < 4; i++) access("R3", 16'h0100, 1'b1, 1'b0, 1'b0, 0, 6'd0);
        for (int i = 0; i < 4; i++) access("R3", 16'h0200, 1'b0, 1'b1, 1'b1, 0, 6'd0);
        chk("R3", overlay_on, 1'b1);
    endtask

    task automatic t_clear();
        for (int i = 0; i < 7; i++) access("R3", 16'(i), 1'b1, 1'b0, 1'b1, 0, 6'd0);
        chk("R3", overlay_on, 1'b1);
        probe("R3", 16'h0000, 16'h4000);
        access("R3", 16'h0007, 1'b1, 1'b0, 1'b1, 0, 6'd0);
        chk("R3", overlay_on, 1'b0);
        probe("R4", 16'h0000, 16'h0000);
    endtask

    task automatic t_sticky();
        for (int i = 0; i < 3; i++) access("R4", 16'h0010, 1'b1, 1'b0, 1'b1, 0, 6'd0);
        chk("R4", overlay_on, 1'b0);
        probe("R4", 16'h5555, 16'h5555);
        probe("R4", 16'h3ABC, 16'h3ABC);
    endtask

    task automatic t_decode();
        for (int c = 0; c < 8; c++) begin
            access("R5", 16'h8000 | 16'(c), 1'b0, 1'b1, 1'b0, 0, expect_code(3'(c)));
            access("R5", 16'hBFF8 | 16'(c), 1'b1, 1'b0, 1'b0, 0, expect_code(3'(c)));
        end
    endtask

    task automatic t_hold();
        access("R6", 16'h8004, 1'b0, 1'b1, 1'b0, 3, 6'b001000);
        access("R6", 16'h9006, 1'b1, 1'b0, 1'b0, 2, 6'b100000);
    endtask

    task automatic t_reject();
        access("R8", 16'h4002, 1'b0, 1'b1, 1'b0, 0, 6'd0);
        access("R8", 16'hC002, 1'b0, 1'b1, 1'b0, 0, 6'd0);
        access("R8", 16'h0005, 1'b1, 1'b0, 1'b0, 0, 6'd0);
        access("R8", 16'h8003, 1'b1, 1'b1, 1'b0, 0, 6'd0);
        access("R8", 16'h8003, 1'b0, 1'b0, 1'b0, 0, 6'd0);
        @(negedge clk);
        addr = 16'h8002; wr = 1'b1; acc_stb = 1'b0;
        repeat (2) begin
            @(posedge clk); #1;
            chk("R8", strobes(), 6'd0);
        end
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic t_rereset();
        do_reset();
        @(posedge clk); #1;
        chk("R10", overlay_on, 1'b1);
        probe("R10", 16'h0000, 16'h4000);
        access("R10", 16'h8002, 1'b0, 1'b1, 1'b0, 0, 6'd0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_overlay_map();
                t_nonfetch();
                t_clear();
                t_sticky();
                t_decode();
                t_hold();
                t_reject();
                t_rereset();
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule